// File: doc/BRIEF.md
# Windowed Channel Weighting and Beam Summation Stage

This stage sits at the end of a receive delay-and-sum chain. Every sample period it takes one signed fine-delayed sample from each array channel, all presented together under a single valid strobe. Each channel sample is scaled by a fixed Q1.31 weight that belongs to that channel. The scaled channels are added in a registered tree into one 64-bit beam sample, and the beam samples of a scan line are stored in a two-half output buffer.

The weights come from constant tapers that are computed when the design is elaborated. An operator picks the taper with a two-bit select. The select is taken only on the first sample of each line, so every line is built with a single taper. While one buffer half collects the current line, a reader fetches the previous line from the other half through a registered read port. A one-cycle ready pulse marks each completed line. On that pulse the halves swap roles.

Top module: `beam_apod_sum`

## Requirements
- R1: During and after a synchronous active-low reset, `line_done` is 0 and `rd_data` is 0.
- R2: Taper select 0 gives weight w(n)=0.5-0.5cos(2π(n+1)/(N+1)). Select 1 gives w(n)=0.54-0.46cos(2πn/(N-1)). Select 2 gives the Kaiser weight I0(4·sqrt(1-(2n/(N-1)-1)²))/I0(4). In every case n is the channel index and N is the channel count. Each weight is stored as the nearest value of w·2^31, limited to 0x7FFFFFFF.
- R3: Taper select 3 has no table and gives a flat taper: every weight is 0x7FFFFFFF.
- R4: Each beam sample is the sum over channels of the signed 32-bit sample of channel c (bits 32c+31..32c of `ch_samples`) times the signed Q1.31 weight of channel c. Each product is formed at full 64-bit width.
- R5: When the sum exceeds the signed 64-bit range, the stored sample is clamped to 0x7FFF_FFFF_FFFF_FFFF or 0x8000_0000_0000_0000. It never wraps.
- R6: `line_done` rises clog2(N)+2 clock edges after the edge that accepts the last sample of a line: one multiply stage, clog2(N) tree stages and one buffer write.
- R7: `line_done` is a single-cycle pulse per completed line. Each pulse swaps the half being written.
- R8: `rd_data` returns, one edge after `rd_addr` is sampled, the beam sample with line index `rd_addr` from the half not being written.
- R9: The taper select is sampled only together with the first valid sample of a line. Changes at later samples of that line have no effect on it.
- R10: A line holds `line_len` samples. A value of 0, or a value above DEPTH, means DEPTH samples.
- R11: Writes into the half being filled never change what the read port returns from the other half.
- R12: Cycles with `ch_valid` low move nothing: they neither count as samples nor write the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_valid | input | 1 | All channel samples valid this cycle |
| ch_samples | input | NCH*SW | Channel c at bits 32c+31..32c, signed |
| taper_sel | input | 2 | 0 raised cosine, 1 Hamming, 2 Kaiser, 3 flat |
| line_len | input | clog2(DEPTH)+1 | Samples per line; 0 or above DEPTH means DEPTH |
| rd_addr | input | clog2(DEPTH) | Sample index to read from the inactive half |
| rd_data | output | SW+32 | Registered read data |
| line_done | output | 1 | One-cycle pulse when a half completes |

## Verification
The hardest case to reach from the ports is a taper change in the middle of a line. The select has to move while samples are already flowing, and the buffer must then be shown to hold only weights from the select that was present at the line's first sample. The bench changes the select on every sample after the first. It drives unit impulses that walk across the channels, so each stored sample equals one weight of one channel, and every weight of every taper is then read back and compared with the value the bench computes. Reads from the full half are also repeated while a line is half written into the other half, which shows the two halves are kept apart.

// File: rtl/apod_pkg.sv
// Shared constants and elaboration-time taper arithmetic for the beam
// weighting stage. Assumes weights are non-negative and below 1.0.
package apod_pkg;

    localparam int          COEF_W     = 32;
    localparam int          SEL_W      = 2;
    localparam logic [1:0]  TAPER_RCOS = 2'd0;
    localparam logic [1:0]  TAPER_HAMM = 2'd1;
    localparam logic [1:0]  TAPER_KAIS = 2'd2;
    localparam logic [31:0] FLAT_Q31   = 32'h7FFF_FFFF;
    localparam real         PI_R       = 3.14159265358979323846;
    localparam real         KBETA      = 4.0;

    // Modified Bessel function of order zero, truncated power series.
    function automatic real bessel0(input real x);
        real term;
        real acc;
        term = 1.0;
        acc  = 1.0;
        for (int k = 1; k < 25; k++) begin
            term = term * (x / 2.0) / real'(k);
            acc  = acc + term * term;
        end
        return acc;
    endfunction

    // Quantised Q1.31 weight of channel idx out of n for a given taper.
    function automatic longint taper_q31(input int sel, input int idx, input int n);
        real    w;
        real    pos;
        longint q;
        if (n < 2) begin
            w = 1.0;
        end else begin
            case (sel)
                0: w = 0.5 - 0.5 * $cos(2.0 * PI_R * real'(idx + 1) / real'(n + 1));
                1: w = 0.54 - 0.46 * $cos(2.0 * PI_R * real'(idx) / real'(n - 1));
                2: begin
                    pos = 2.0 * real'(idx) / real'(n - 1) - 1.0;
                    w   = bessel0(KBETA * $sqrt(1.0 - pos * pos)) / bessel0(KBETA);
                end
                default: w = 1.0;
            endcase
        end
        q = longint'(w * 2147483648.0);
        if (q > 64'sd2147483647) q = 64'sd2147483647;
        if (q < 0) q = 0;
        return q;
    endfunction

endpackage

// File: rtl/apod_weight_rom.sv
// Constant taper table: returns the weight of every channel for the chosen
// taper. Pure combinational; unmapped select codes give a flat taper.
module apod_weight_rom #(
    parameter int NCH = 32
) (
    input  logic [apod_pkg::SEL_W-1:0]                sel,
    output logic [NCH-1:0][apod_pkg::COEF_W-1:0]      weights
);
    import apod_pkg::*;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [COEF_W-1:0] W_RCOS = COEF_W'(taper_q31(0, c, NCH));
        localparam logic [COEF_W-1:0] W_HAMM = COEF_W'(taper_q31(1, c, NCH));
        localparam logic [COEF_W-1:0] W_KAIS = COEF_W'(taper_q31(2, c, NCH));

        // Pick this channel's weight from the stored tapers.
        always_comb begin
            case (sel)
                TAPER_RCOS: weights[c] = W_RCOS;
                TAPER_HAMM: weights[c] = W_HAMM;
                TAPER_KAIS: weights[c] = W_KAIS;
                default:    weights[c] = FLAT_Q31;
            endcase
        end
    end

endmodule

// File: rtl/apod_sum_tree.sv
// Registered pairwise adder tree with saturation at every node.
// Assumes NIN >= 2; inputs are padded with zeros to a power of two.
module apod_sum_tree #(
    parameter int NIN = 32,
    parameter int W   = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [NIN-1:0][W-1:0]  in_terms,
    output logic                   out_valid,
    output logic [W-1:0]           out_sum
);
    localparam int LVL = $clog2(NIN);
    localparam int NP  = 1 << LVL;
    localparam int HP  = NP / 2;

    logic [NP-1:0][W-1:0]          leaf;
    logic [LVL-1:0][NP-1:0][W-1:0] opnd;
    logic [LVL-1:0][HP-1:0][W-1:0] st_q;
    logic [LVL-1:0]                vld_q;

    // Two's complement add that clamps instead of wrapping.
    function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        s = {a[W-1], a} + {b[W-1], b};
        if (s[W] != s[W-1])
            return s[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        return s[W-1:0];
    endfunction

    for (genvar j = 0; j < NP; j++) begin : g_leaf
        if (j < NIN) begin : g_used
            assign leaf[j] = in_terms[j];
        end else begin : g_pad
            assign leaf[j] = '0;
        end
    end

    // Operand routing: level 0 reads the leaves, later levels read registers.
    always_comb begin
        opnd    = '0;
        opnd[0] = leaf;
        for (int l = 1; l < LVL; l++) begin
            for (int j = 0; j < HP; j++) opnd[l][j] = st_q[l-1][j];
        end
    end

    // One register rank per tree level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            for (int l = 0; l < LVL; l++) begin
                for (int j = 0; j < HP; j++)
                    st_q[l][j] <= sat_add(opnd[l][2*j], opnd[l][2*j+1]);
            end
        end
    end

    // Valid travels alongside the data ranks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= in_valid;
            for (int l = 1; l < LVL; l++) vld_q[l] <= vld_q[l-1];
        end
    end

    assign out_valid = vld_q[LVL-1];
    assign out_sum   = st_q[LVL-1][0];

endmodule

// File: rtl/apod_pingpong.sv
// Two-half line store: the write side fills one half sample by sample and
// swaps halves when a line completes; reads always come from the other half.
// Assumes line_eff lies in 1..DEPTH. Storage itself is not reset.
module apod_pingpong #(
    parameter int W     = 64,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [W-1:0]               wr_data,
    input  logic [$clog2(DEPTH):0]     line_eff,
    input  logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [W-1:0]               rd_data,
    output logic                       half_done,
    output logic                       wr_half
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [2*DEPTH];
    logic [AW:0]  wr_idx;

    // Write index, half selection and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx    <= '0;
            wr_half   <= 1'b0;
            half_done <= 1'b0;
        end else begin
            half_done <= 1'b0;
            if (wr_valid) begin
                if (wr_idx == line_eff - 1'b1) begin
                    wr_idx    <= '0;
                    wr_half   <= ~wr_half;
                    half_done <= 1'b1;
                end else begin
                    wr_idx <= wr_idx + 1'b1;
                end
            end
        end
    end

    // Store the beam sample into the half being filled.
    always_ff @(posedge clk) begin
        if (wr_valid) mem[{wr_half, wr_idx[AW-1:0]}] <= wr_data;
    end

    // Registered read from the half not being written.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[{~wr_half, rd_addr}];
    end

endmodule

// File: rtl/beam_apod_sum.sv
// Beam weighting and summation top: latches the taper at each line start,
// multiplies every channel by its weight, sums through a saturating tree and
// stores lines in a two-half buffer. Assumes NCH >= 2 and DEPTH >= 2, and
// that line_len is held steady while a line is in flight.
module beam_apod_sum #(
    parameter int NCH   = 32,
    parameter int SW    = 32,
    parameter int DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ch_valid,
    input  logic [NCH*SW-1:0]             ch_samples,
    input  logic [1:0]                    taper_sel,
    input  logic [$clog2(DEPTH):0]        line_len,
    input  logic [$clog2(DEPTH)-1:0]      rd_addr,
    output logic [SW+apod_pkg::COEF_W-1:0] rd_data,
    output logic                          line_done
);
    import apod_pkg::*;

    localparam int ACC_W = SW + COEF_W;
    localparam int AW    = $clog2(DEPTH);
    localparam int LEN_W = AW + 1;

    logic [LEN_W-1:0]               len_eff;
    logic [LEN_W-1:0]               in_cnt;
    logic [SEL_W-1:0]               held_sel;
    logic [SEL_W-1:0]               use_sel;
    logic [NCH-1:0][COEF_W-1:0]     wts;
    logic [NCH-1:0][ACC_W-1:0]      prod_q;
    logic                           mul_vld;
    logic                           sum_vld;
    logic [ACC_W-1:0]               sum_val;
    logic                           buf_half;

    // Clamp the programmed line length into 1..DEPTH.
    always_comb begin
        if (line_len == '0 || line_len > LEN_W'(DEPTH)) len_eff = LEN_W'(DEPTH);
        else                                             len_eff = line_len;
    end

    // The first sample of a line uses the live select; the rest use the latch.
    assign use_sel = (in_cnt == '0) ? taper_sel : held_sel;

    // Input-side sample count and taper latch per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt   <= '0;
            held_sel <= '0;
        end else if (ch_valid) begin
            if (in_cnt == '0) held_sel <= taper_sel;
            if (in_cnt == len_eff - 1'b1) in_cnt <= '0;
            else                          in_cnt <= in_cnt + 1'b1;
        end
    end

    apod_weight_rom #(.NCH(NCH)) u_rom (
        .sel     (use_sel),
        .weights (wts)
    );

    // Multiply stage: full-width signed channel products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            mul_vld <= 1'b0;
        end else begin
            mul_vld <= ch_valid;
            for (int c = 0; c < NCH; c++)
                prod_q[c] <= ACC_W'($signed(ch_samples[c*SW +: SW])) *
                             ACC_W'($signed(wts[c]));
        end
    end

    apod_sum_tree #(.NIN(NCH), .W(ACC_W)) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mul_vld),
        .in_terms  (prod_q),
        .out_valid (sum_vld),
        .out_sum   (sum_val)
    );

    apod_pingpong #(.W(ACC_W), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (sum_vld),
        .wr_data   (sum_val),
        .line_eff  (len_eff),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .half_done (line_done),
        .wr_half   (buf_half)
    );

endmodule

// File: rtl/beam_apod_sum_chk.sv
// Temporal checks on the beam weighting stage, attached by bind.
module beam_apod_sum_chk #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ch_valid,
    input logic             mul_vld,
    input logic             sum_vld,
    input logic             line_done,
    input logic             buf_half,
    input logic [CNT_W-1:0] in_cnt,
    input logic [1:0]       held_sel
);
    AST_MUL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ch_valid |=> mul_vld); // R6
    AST_IDLE_NO_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_valid |=> !mul_vld); // R12
    AST_DONE_FROM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> $past(sum_vld)); // R7
    AST_DONE_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (buf_half != $past(buf_half))); // R7
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt != '0) |=> $stable(held_sel)); // R9
endmodule

bind beam_apod_sum beam_apod_sum_chk #(.CNT_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_valid  (ch_valid),
    .mul_vld   (mul_vld),
    .sum_vld   (sum_vld),
    .line_done (line_done),
    .buf_half  (buf_half),
    .in_cnt    (in_cnt),
    .held_sel  (held_sel)
);

// File: tb/beam_apod_sum_tb_top.sv
// Self-checking bench on a 4-channel, 8-deep configuration.
module beam_apod_sum_tb_top;
    localparam int NCH   = 4;
    localparam int SW    = 32;
    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam int LAT   = 4;   // clog2(4) + 2

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ch_valid = 1'b0;
    logic [NCH*SW-1:0] ch_samples = '0;
    logic [1:0]        taper_sel = '0;
    logic [AW:0]       line_len = '0;
    logic [AW-1:0]     rd_addr = '0;
    logic [63:0]       rd_data;
    logic              line_done;

    int     n_tests = 0;
    int     n_fail  = 0;
    bit     finished = 1'b0;
    longint wtab [4][NCH];

    always #2.5 clk = ~clk;

    beam_apod_sum #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_samples(ch_samples),
        .taper_sel(taper_sel), .line_len(line_len), .rd_addr(rd_addr),
        .rd_data(rd_data), .line_done(line_done)
    );

    function automatic real i0_ref(input real x);
        real t = 1.0;
        real s = 1.0;
        for (int k = 1; k < 25; k++) begin
            t = t * (x / 2.0) / real'(k);
            s = s + t * t;
        end
        return s;
    endfunction

    function automatic longint ref_weight(input int sel, input int n);
        real    w;
        real    u;
        longint q;
        real    pi = 3.14159265358979323846;
        if (sel == 0)      w = 0.5 - 0.5 * $cos(2.0 * pi * real'(n + 1) / real'(NCH + 1));
        else if (sel == 1) w = 0.54 - 0.46 * $cos(2.0 * pi * real'(n) / real'(NCH - 1));
        else if (sel == 2) begin
            u = 2.0 * real'(n) / real'(NCH - 1) - 1.0;
            w = i0_ref(4.0 * $sqrt(1.0 - u * u)) / i0_ref(4.0);
        end else w = 1.0;
        q = longint'(w * 2147483648.0);
        if (q > 64'sd2147483647) q = 64'sd2147483647;
        return q;
    endfunction

    function automatic logic [31:0] gen(input int pat, input int i, input int c);
        case (pat)
            0: return (c == i % NCH) ? 32'd1 : 32'd0;
            1: return 32'(i * 32'h9E37_79B9) ^ 32'(c * 32'h85EB_CA6B) ^ 32'h0123_4567;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            default: return (c < 2) ? 32'h7FFF_FFFF : 32'h8000_0000;
        endcase
    endfunction

    function automatic logic [63:0] expect_sum(input int pat, input int i, input int sel);
        logic signed [67:0] acc = '0;
        longint p;
        for (int c = 0; c < NCH; c++) begin
            p   = longint'($signed(gen(pat, i, c))) * wtab[sel][c];
            acc = acc + 68'(p);
        end
        if (acc > 68'sh0_7FFF_FFFF_FFFF_FFFF) return 64'h7FFF_FFFF_FFFF_FFFF;
        if (acc < -68'sh0_8000_0000_0000_0000) return 64'h8000_0000_0000_0000;
        return acc[63:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive samples first..last; the select differs from sel after index 0.
    task automatic drive(input int sel, input int pat, input int first, input int last, input bit gap);
        for (int i = first; i <= last; i++) begin
            if (gap && i == first + 2) begin
                @(negedge clk);
                ch_valid   = 1'b0;
                ch_samples = '1;
            end
            @(negedge clk);
            ch_valid  = 1'b1;
            taper_sel = (i == 0) ? 2'(sel) : 2'(sel + 1 + i);
            for (int c = 0; c < NCH; c++) ch_samples[c*SW +: SW] = gen(pat, i, c);
        end
        @(negedge clk);
        ch_valid  = 1'b0;
        taper_sel = 2'(sel + 2);
    endtask

    // Called one cycle after the last sample edge: pulse expected at k == LAT only.
    task automatic wait_done(input string req);
        for (int k = 1; k <= LAT + 1; k++) begin
            if (k > 1) @(negedge clk);
            check(line_done == (k == LAT), req, 64'(line_done), 64'(k == LAT));
        end
    endtask

    task automatic read_line(input int len, input int pat, input int sel, input string req);
        logic [63:0] e;
        for (int a = 0; a < len; a++) begin
            @(negedge clk);
            rd_addr = AW'(a);
            @(negedge clk);
            e = expect_sum(pat, a, sel);
            check(rd_data == e, req, rd_data, e);
        end
    endtask

    initial begin
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < NCH; c++) wtab[s][c] = ref_weight(s, c);
        repeat (3) @(negedge clk);
        check(line_done == 1'b0, "R1 done", 64'(line_done), 64'd0);
        check(rd_data == 64'd0, "R1 data", rd_data, 64'd0);
        rst_n = 1'b1;
        line_len = 4'd8;
        @(negedge clk);
        check(line_done == 1'b0, "R1 after", 64'(line_done), 64'd0);

        // R2 / R3 / R9: impulses expose every weight; select churns mid-line
        for (int s = 0; s < 4; s++) begin
            drive(s, 0, 0, DEPTH - 1, 1'b0);
            wait_done("R6 R7 latency");
            read_line(DEPTH, 0, s, (s == 3) ? "R3 flat taper" : "R2 R9 taper weights");
        end
        // R4 / R12: mixed data with an idle gap
        drive(1, 1, 0, DEPTH - 1, 1'b1);
        wait_done("R12 gap latency");
        read_line(DEPTH, 1, 1, "R4 R12 weighted sum");
        // R5: saturation both ways and a non-saturating full-scale mix
        drive(3, 2, 0, DEPTH - 1, 1'b0);
        wait_done("R5 latency");
        read_line(DEPTH, 2, 3, "R5 positive clamp");
        drive(3, 3, 0, DEPTH - 1, 1'b0);
        wait_done("R5 latency");
        read_line(DEPTH, 3, 3, "R5 negative clamp");
        drive(3, 4, 0, DEPTH - 1, 1'b0);
        wait_done("R5 latency");
        read_line(DEPTH, 4, 3, "R5 mixed no clamp");
        // R10: short, zero and oversize lengths
        line_len = 4'd3;
        drive(2, 1, 0, 2, 1'b0);
        wait_done("R10 length 3");
        read_line(3, 1, 2, "R10 short line");
        line_len = 4'd0;
        drive(0, 1, 0, DEPTH - 1, 1'b0);
        wait_done("R10 length 0");
        read_line(DEPTH, 1, 0, "R10 zero length");
        line_len = 4'd12;
        drive(2, 1, 0, DEPTH - 1, 1'b0);
        wait_done("R10 length 12");
        read_line(DEPTH, 1, 2, "R8 R10 oversize line");
        // R11: partial writes into the other half leave this half unchanged
        line_len = 4'd8;
        drive(1, 0, 0, 1, 1'b0);
        repeat (LAT + 2) @(negedge clk);
        read_line(DEPTH, 1, 2, "R11 reads isolated");
        drive(1, 0, 2, DEPTH - 1, 1'b0);
        wait_done("R7 resumed line");
        read_line(DEPTH, 0, 1, "R8 R11 second half");

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule